// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

This block sits between the interrupt sources that belong to a cluster of up to four processor cores and the two request inputs (normal and fast) of each core. Every core owns four timer lines and four mailbox lines, plus a performance-monitor line. A single system-level interrupt is shared by the whole cluster and is steered to one chosen core. Software programs the steering through a small register bus. The block then presents, per core, two read-only pending words and an active-high normal request and fast request.

For the per-core timer and mailbox sources, each source has a normal-request enable and a fast-request enable. When the fast enable is set it wins, so an enabled source reaches exactly one of the two request lines. The shared system interrupt has one core selector for the normal path and an independent selector for the fast path. Performance-monitor lines are turned on and off through a write-one-to-set word and a write-one-to-clear word. They are always reported on the normal path.

Pending words are not latched. They show the present level of each enabled source, so a request drops as soon as its source drops or its enable is removed. Register writes take effect at the clock edge that samples them. Reads are combinational from the address.

Top module: `lir_router`

## Requirements
- R1: After synchronous reset, all timer and mailbox enables and all performance-monitor enables read as zero, the system-interrupt route word (offset 0x0C) reads zero (both selectors point to core 0), and with all sources low every request output is low.
- R2: The timer control word of core c is at offset 0x40+4c. Bits 3:0 are normal enables and bits 7:4 are fast enables for timers 0..3. Timer t is reported in bit t of the core's normal pending word when its normal enable is set and its fast enable is clear. It is reported in bit t of the fast pending word whenever its fast enable is set.
- R3: The mailbox control word of core c is at offset 0x50+4c and has the same layout as the timer word. Mailbox m appears in bit 4+m of the normal or fast pending word under the same rule, with the fast enable taking priority.
- R4: In the route word, bits 1:0 select the core whose normal pending bit 8 follows the shared system interrupt, and bits 3:2 select the core whose fast pending bit 8 follows it. Bit 8 is zero for every other core.
- R5: A write to offset 0x10 sets the performance-monitor enable of each core whose bit in 3:0 is one. A write to 0x14 clears them. Zero bits leave enables unchanged, and both offsets read back the enable mask. An enabled core shows its monitor line in normal pending bit 9. Fast pending bit 9 is always zero.
- R6: The normal pending word of core c is read at 0x60+4c and its fast pending word at 0x70+4c, in bits 9:0 with upper bits zero. irq_out[c] is high exactly when that core's normal pending word is non-zero, and fiq_out[c] is high exactly when its fast pending word is non-zero.
- R7: Pending words are read-only: writes to 0x60..0x7C change no state. Pending bits follow source levels in the same cycle, with no latching.
- R8: Control words read back the written fields only (8 bits for timer and mailbox words, 4 bits for the route word), with the upper bits zero. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| tmr_src | input | 4*NUM_CORES | Timer lines, core-major: bit 4c+t is timer t of core c |
| mbx_src | input | 4*NUM_CORES | Mailbox lines, core-major: bit 4c+m is mailbox m of core c |
| gpu_src | input | 1 | Shared system interrupt |
| pmu_src | input | NUM_CORES | Performance-monitor line per core |
| irq_out | output | NUM_CORES | Normal request per core, active high |
| fiq_out | output | NUM_CORES | Fast request per core, active high |

## Verification
Two functions can fall in the same cycle. A control write can change an enable, route or monitor mask in the same cycle that the source levels move. The bench provokes this by changing sources and issuing random writes back to back. It then judges each pending word and request line right after the write edge against a model that applies the new configuration to the new source levels. The override rule and the route collision are covered too: both selectors naming the same core, and fast and normal enables set together. Directed checks cover these next to the random mix.

// File: rtl/lir_pkg.sv
package lir_pkg;

    localparam int MAX_CORES = 4;
    localparam int CORE_W    = 2;
    localparam int SRC_PER   = 4;
    localparam int PEND_W    = 10;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;

    // pending-word bit positions (decoded by software)
    localparam int PB_TMR  = 0;
    localparam int PB_MBX  = 4;
    localparam int PB_GPU  = 8;
    localparam int PB_PMU  = 9;

    // register offsets
    localparam logic [ADDR_W-1:0] OFS_ROUTE  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_PMUSET = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_PMUCLR = 8'h14;
    localparam logic [3:0]        BANK_TMR   = 4'h4;
    localparam logic [3:0]        BANK_MBX   = 4'h5;
    localparam logic [3:0]        BANK_IRQP  = 4'h6;
    localparam logic [3:0]        BANK_FIQP  = 4'h7;

    typedef struct packed {
        logic [SRC_PER-1:0] fast_en;
        logic [SRC_PER-1:0] norm_en;
    } src_ctl_t;

    typedef struct packed {
        logic [CORE_W-1:0] fast_core;
        logic [CORE_W-1:0] norm_core;
    } gpu_route_t;

    typedef struct packed {
        logic [PEND_W-1:0] fast;
        logic [PEND_W-1:0] norm;
    } pend_pair_t;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_ROUTE,
        RK_PMUSET,
        RK_PMUCLR,
        RK_TMR,
        RK_MBX,
        RK_IRQP,
        RK_FIQP
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e         kind;
        logic [CORE_W-1:0] idx;
    } reg_sel_t;

    // decode an offset into a register kind and a core index
    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a,
                                             input int unsigned      ncores);
        reg_sel_t s;
        s.kind = RK_NONE;
        s.idx  = a[3:2];
        if (a[1:0] == 2'b00) begin
            if (a == OFS_ROUTE)       s.kind = RK_ROUTE;
            else if (a == OFS_PMUSET) s.kind = RK_PMUSET;
            else if (a == OFS_PMUCLR) s.kind = RK_PMUCLR;
            else if (32'(a[3:2]) < ncores) begin
                case (a[7:4])
                    BANK_TMR:  s.kind = RK_TMR;
                    BANK_MBX:  s.kind = RK_MBX;
                    BANK_IRQP: s.kind = RK_IRQP;
                    BANK_FIQP: s.kind = RK_FIQP;
                    default:   s.kind = RK_NONE;
                endcase
            end
        end
        return s;
    endfunction

    // fast enable wins: each source reaches one path at most
    function automatic logic [2*SRC_PER-1:0] steer_group(input logic [SRC_PER-1:0] src,
                                                         input src_ctl_t          ctl);
        logic [SRC_PER-1:0] f;
        logic [SRC_PER-1:0] n;
        f = src & ctl.fast_en;
        n = src & ctl.norm_en & ~ctl.fast_en;
        return {f, n};
    endfunction

endpackage

// File: rtl/lir_regs.sv
module lir_regs
    import lir_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output src_ctl_t [NUM_CORES-1:0]      tmr_ctl,
    output src_ctl_t [NUM_CORES-1:0]      mbx_ctl,
    output gpu_route_t                    route,
    output logic [NUM_CORES-1:0]          pmu_en
);

    reg_sel_t sel;

    always_comb sel = decode_addr(wr_addr, NUM_CORES);

    always_ff @(posedge clk) begin
        if (rst) begin
            route  <= '0;
            pmu_en <= '0;
        end else if (wr_en) begin
            case (sel.kind)
                RK_ROUTE:  route  <= gpu_route_t'(wr_data[2*CORE_W-1:0]);
                RK_PMUSET: pmu_en <= pmu_en | wr_data[NUM_CORES-1:0];
                RK_PMUCLR: pmu_en <= pmu_en & ~wr_data[NUM_CORES-1:0];
                default: ;
            endcase
        end
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_ctl
        always_ff @(posedge clk) begin
            if (rst) begin
                tmr_ctl[c] <= '0;
                mbx_ctl[c] <= '0;
            end else if (wr_en && 32'(sel.idx) == c) begin
                if (sel.kind == RK_TMR) tmr_ctl[c] <= src_ctl_t'(wr_data[2*SRC_PER-1:0]);
                if (sel.kind == RK_MBX) mbx_ctl[c] <= src_ctl_t'(wr_data[2*SRC_PER-1:0]);
            end
        end
    end

endmodule

// File: rtl/lir_core_steer.sv
module lir_core_steer
    import lir_pkg::*;
#(
    parameter int CORE_ID = 0
) (
    input  logic [SRC_PER-1:0] tmr_lines,
    input  logic [SRC_PER-1:0] mbx_lines,
    input  src_ctl_t           tmr_ctl,
    input  src_ctl_t           mbx_ctl,
    input  logic               gpu_line,
    input  gpu_route_t         route,
    input  logic               pmu_line,
    input  logic               pmu_on,
    output pend_pair_t         pend,
    output logic               irq_req,
    output logic               fiq_req
);

    logic [2*SRC_PER-1:0] tmr_split;
    logic [2*SRC_PER-1:0] mbx_split;
    logic                 gpu_norm_hit;
    logic                 gpu_fast_hit;

    always_comb begin
        tmr_split    = steer_group(tmr_lines, tmr_ctl);
        mbx_split    = steer_group(mbx_lines, mbx_ctl);
        gpu_norm_hit = gpu_line && (32'(route.norm_core) == CORE_ID);
        gpu_fast_hit = gpu_line && (32'(route.fast_core) == CORE_ID);

        pend = '0;
        pend.norm[PB_TMR +: SRC_PER] = tmr_split[SRC_PER-1:0];
        pend.norm[PB_MBX +: SRC_PER] = mbx_split[SRC_PER-1:0];
        pend.norm[PB_GPU]            = gpu_norm_hit;
        pend.norm[PB_PMU]            = pmu_line && pmu_on;
        pend.fast[PB_TMR +: SRC_PER] = tmr_split[2*SRC_PER-1:SRC_PER];
        pend.fast[PB_MBX +: SRC_PER] = mbx_split[2*SRC_PER-1:SRC_PER];
        pend.fast[PB_GPU]            = gpu_fast_hit;
        pend.fast[PB_PMU]            = 1'b0;

        irq_req = |pend.norm;
        fiq_req = |pend.fast;
    end

endmodule

// File: rtl/lir_readmux.sv
module lir_readmux
    import lir_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic [ADDR_W-1:0]             rd_addr,
    input  src_ctl_t [NUM_CORES-1:0]      tmr_ctl,
    input  src_ctl_t [NUM_CORES-1:0]      mbx_ctl,
    input  gpu_route_t                    route,
    input  logic [NUM_CORES-1:0]          pmu_en,
    input  pend_pair_t [NUM_CORES-1:0]    pend,
    output logic [DATA_W-1:0]             rd_data
);

    reg_sel_t sel;

    always_comb begin
        sel     = decode_addr(rd_addr, NUM_CORES);
        rd_data = '0;
        case (sel.kind)
            RK_ROUTE:  rd_data[2*CORE_W-1:0]  = route;
            RK_PMUSET,
            RK_PMUCLR: rd_data[NUM_CORES-1:0] = pmu_en;
            RK_TMR:    rd_data[2*SRC_PER-1:0] = tmr_ctl[sel.idx];
            RK_MBX:    rd_data[2*SRC_PER-1:0] = mbx_ctl[sel.idx];
            RK_IRQP:   rd_data[PEND_W-1:0]    = pend[sel.idx].norm;
            RK_FIQP:   rd_data[PEND_W-1:0]    = pend[sel.idx].fast;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/lir_router.sv
module lir_router
    import lir_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           bus_wr,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    input  logic [SRC_PER*NUM_CORES-1:0]   tmr_src,
    input  logic [SRC_PER*NUM_CORES-1:0]   mbx_src,
    input  logic                           gpu_src,
    input  logic [NUM_CORES-1:0]           pmu_src,
    output logic [NUM_CORES-1:0]           irq_out,
    output logic [NUM_CORES-1:0]           fiq_out
);

    localparam int FLAT_W = NUM_CORES * PEND_W;

    src_ctl_t   [NUM_CORES-1:0] tmr_ctl;
    src_ctl_t   [NUM_CORES-1:0] mbx_ctl;
    gpu_route_t                 route;
    logic       [NUM_CORES-1:0] pmu_en;
    pend_pair_t [NUM_CORES-1:0] pend;
    logic       [FLAT_W-1:0]    norm_pend_flat;
    logic       [FLAT_W-1:0]    fast_pend_flat;

    lir_regs #(.NUM_CORES(NUM_CORES)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wr),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .tmr_ctl (tmr_ctl),
        .mbx_ctl (mbx_ctl),
        .route   (route),
        .pmu_en  (pmu_en)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        lir_core_steer #(.CORE_ID(c)) u_steer (
            .tmr_lines (tmr_src[c*SRC_PER +: SRC_PER]),
            .mbx_lines (mbx_src[c*SRC_PER +: SRC_PER]),
            .tmr_ctl   (tmr_ctl[c]),
            .mbx_ctl   (mbx_ctl[c]),
            .gpu_line  (gpu_src),
            .route     (route),
            .pmu_line  (pmu_src[c]),
            .pmu_on    (pmu_en[c]),
            .pend      (pend[c]),
            .irq_req   (irq_out[c]),
            .fiq_req   (fiq_out[c])
        );
        assign norm_pend_flat[c*PEND_W +: PEND_W] = pend[c].norm;
        assign fast_pend_flat[c*PEND_W +: PEND_W] = pend[c].fast;
    end

    lir_readmux #(.NUM_CORES(NUM_CORES)) u_rd (
        .rd_addr (bus_addr),
        .tmr_ctl (tmr_ctl),
        .mbx_ctl (mbx_ctl),
        .route   (route),
        .pmu_en  (pmu_en),
        .pend    (pend),
        .rd_data (bus_rdata)
    );

endmodule

// File: rtl/lir_router_chk.sv
module lir_router_chk
    import lir_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          bus_wr,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [DATA_W-1:0]             bus_wdata,
    input logic [NUM_CORES-1:0]          pmu_src,
    input logic [NUM_CORES-1:0]          pmu_en,
    input logic                          gpu_src,
    input logic [NUM_CORES-1:0]          irq_out,
    input logic [NUM_CORES-1:0]          fiq_out,
    input logic [NUM_CORES*PEND_W-1:0]   norm_pend_flat,
    input logic [NUM_CORES*PEND_W-1:0]   fast_pend_flat
);

    logic [NUM_CORES-1:0] gpu_norm_bits;
    logic [NUM_CORES-1:0] gpu_fast_bits;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_bits
        assign gpu_norm_bits[c] = norm_pend_flat[c*PEND_W + PB_GPU];
        assign gpu_fast_bits[c] = fast_pend_flat[c*PEND_W + PB_GPU];

        // R2 / R3: no timer or mailbox is reported on both paths
        a_r2_path_exclusive: assert property (@(posedge clk) disable iff (rst)
            (norm_pend_flat[c*PEND_W +: 8] & fast_pend_flat[c*PEND_W +: 8]) == 8'h00);

        // R5: enabled monitor line with its source high raises the normal request
        a_r5_pmu_raises_irq: assert property (@(posedge clk) disable iff (rst)
            (pmu_en[c] && pmu_src[c]) |-> irq_out[c]);

        // R5: monitor never appears on the fast path
        a_r5_pmu_not_fast: assert property (@(posedge clk) disable iff (rst)
            fast_pend_flat[c*PEND_W + PB_PMU] == 1'b0);

        // R6: fast request only with some fast pending bit
        a_r6_fiq_matches: assert property (@(posedge clk) disable iff (rst)
            fiq_out[c] == (fast_pend_flat[c*PEND_W +: PEND_W] != '0));
    end

    // R4: shared interrupt lands on one core at most per path
    a_r4_gpu_single: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gpu_norm_bits) && $onehot0(gpu_fast_bits));

    // R4: with the shared line high, exactly one core sees it per path
    a_r4_gpu_present: assert property (@(posedge clk) disable iff (rst)
        gpu_src |-> ($countones(gpu_norm_bits) == 1 && $countones(gpu_fast_bits) == 1));

    // R5: write-one-to-set
    a_r5_pmu_set: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_PMUSET) |=>
            ((pmu_en & $past(bus_wdata[NUM_CORES-1:0])) == $past(bus_wdata[NUM_CORES-1:0])));

    // R5: write-one-to-clear
    a_r5_pmu_clr: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_PMUCLR) |=>
            ((pmu_en & $past(bus_wdata[NUM_CORES-1:0])) == '0));

    // R7: writes elsewhere leave the monitor enables alone
    a_r7_pmu_stable: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr || (bus_addr != OFS_PMUSET && bus_addr != OFS_PMUCLR)) |=> $stable(pmu_en));

endmodule

bind lir_router lir_router_chk #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .bus_wr         (bus_wr),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .pmu_src        (pmu_src),
    .pmu_en         (pmu_en),
    .gpu_src        (gpu_src),
    .irq_out        (irq_out),
    .fiq_out        (fiq_out),
    .norm_pend_flat (norm_pend_flat),
    .fast_pend_flat (fast_pend_flat)
);

// File: tb/tb_lir_router.sv
module tb_lir_router;

    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] tmr_src = '0;
    logic [15:0] mbx_src = '0;
    logic        gpu_src = 1'b0;
    logic [3:0]  pmu_src = '0;
    logic [3:0]  irq_out;
    logic [3:0]  fiq_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // bench model of the programmable state
    logic [7:0] m_tmr [NC];
    logic [7:0] m_mbx [NC];
    logic [3:0] m_route;
    logic [3:0] m_pmu;

    always #5 clk = ~clk;

    lir_router #(.NUM_CORES(NC)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_src(tmr_src),
        .mbx_src(mbx_src), .gpu_src(gpu_src), .pmu_src(pmu_src),
        .irq_out(irq_out), .fiq_out(fiq_out)
    );

    function automatic logic [9:0] exp_norm(input int c);
        logic [9:0] p = '0;
        logic [3:0] t = tmr_src[c*4 +: 4];
        logic [3:0] m = mbx_src[c*4 +: 4];
        for (int i = 0; i < 4; i++) begin
            p[i]   = t[i] && m_tmr[c][i] && !m_tmr[c][4+i];
            p[4+i] = m[i] && m_mbx[c][i] && !m_mbx[c][4+i];
        end
        p[8] = gpu_src && (int'(m_route[1:0]) == c);
        p[9] = pmu_src[c] && m_pmu[c];
        return p;
    endfunction

    function automatic logic [9:0] exp_fast(input int c);
        logic [9:0] p = '0;
        for (int i = 0; i < 4; i++) begin
            p[i]   = tmr_src[c*4+i] && m_tmr[c][4+i];
            p[4+i] = mbx_src[c*4+i] && m_mbx[c][4+i];
        end
        p[8] = gpu_src && (int'(m_route[3:2]) == c);
        return p;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 8'h0C) m_route = d[3:0];
        else if (a == 8'h10) m_pmu = m_pmu | d[3:0];
        else if (a == 8'h14) m_pmu = m_pmu & ~d[3:0];
        else if (a[7:4] == 4'h4 && a[1:0] == 2'b00) m_tmr[a[3:2]] = d[7:0];
        else if (a[7:4] == 4'h5 && a[1:0] == 2'b00) m_mbx[a[3:2]] = d[7:0];
    endtask

    // compare all pending words and request lines against the model
    task automatic check_all(input string tag);
        logic [31:0] d;
        for (int c = 0; c < NC; c++) begin
            rd(8'h60 + 8'(4*c), d);
            check({tag, " R6 norm pend"}, d, {22'd0, exp_norm(c)});
            rd(8'h70 + 8'(4*c), d);
            check({tag, " R6 fast pend"}, d, {22'd0, exp_fast(c)});
            check({tag, " R6 irq_out"}, {31'd0, irq_out[c]}, {31'd0, |exp_norm(c)});
            check({tag, " R6 fiq_out"}, {31'd0, fiq_out[c]}, {31'd0, |exp_fast(c)});
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        logic [31:0] r;
        void'($urandom(32'd2718));
        for (int c = 0; c < NC; c++) begin m_tmr[c] = '0; m_mbx[c] = '0; end
        m_route = '0;
        m_pmu   = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        rd(8'h0C, d); check("R1 route", d, 32'h0);
        rd(8'h10, d); check("R1 pmu mask", d, 32'h0);
        for (int c = 0; c < NC; c++) begin
            rd(8'h40 + 8'(4*c), d); check("R1 timer ctl", d, 32'h0);
            rd(8'h50 + 8'(4*c), d); check("R1 mailbox ctl", d, 32'h0);
        end
        check("R1 irq_out", {28'd0, irq_out}, 32'h0);
        check("R1 fiq_out", {28'd0, fiq_out}, 32'h0);
        tmr_src = '1; mbx_src = '1; pmu_src = '1;
        #1;
        check("R1 sources masked irq", {28'd0, irq_out}, 32'h0);

        // R8: readback widths and unmapped offsets
        wr(8'h44, 32'hFFFF_FFFF);
        rd(8'h44, d); check("R8 timer readback", d, 32'h0000_00FF);
        wr(8'h0C, 32'hFFFF_FFF6);
        rd(8'h0C, d); check("R8 route readback", d, 32'h0000_0006);
        rd(8'h20, d); check("R8 unmapped", d, 32'h0);
        rd(8'h41, d); check("R8 unaligned", d, 32'h0);

        // R2: fast overrides normal for a timer
        wr(8'h44, 32'h0000_0011);
        tmr_src = 16'h0010; mbx_src = '0; pmu_src = '0;
        #1;
        rd(8'h64, d); check("R2 override norm", d, 32'h0);
        rd(8'h74, d); check("R2 override fast", d, 32'h1);
        check_all("R2");

        // R3: mailbox normal path, bits 7:4
        wr(8'h58, 32'h0000_0004);
        mbx_src = 16'h0F00;
        #1;
        rd(8'h68, d); check("R3 mailbox bit6", d, 32'h0000_0040);
        check_all("R3");

        // R4: route to core 3 for both paths, collision on one core
        wr(8'h0C, 32'h0000_000F);
        gpu_src = 1'b1;
        #1;
        rd(8'h6C, d); check("R4 gpu norm core3", d & 32'h100, 32'h100);
        rd(8'h7C, d); check("R4 gpu fast core3", d & 32'h100, 32'h100);
        rd(8'h60, d); check("R4 gpu absent core0", d & 32'h100, 32'h0);
        check_all("R4");

        // R5: set/clear with zero bits not disturbing
        pmu_src = 4'hF;
        wr(8'h10, 32'h0000_0005);
        wr(8'h10, 32'h0000_0000);
        rd(8'h14, d); check("R5 pmu mask", d, 32'h5);
        wr(8'h14, 32'h0000_0001);
        rd(8'h10, d); check("R5 pmu after clr", d, 32'h4);
        rd(8'h78, d); check("R5 fast bit9 zero", d & 32'h200, 32'h0);
        check_all("R5");

        // R7: pending words ignore writes; live tracking of levels
        for (int c = 0; c < NC; c++) begin
            rd(8'h60 + 8'(4*c), r);
            wr(8'h60 + 8'(4*c), 32'hFFFF_FFFF);
            wr(8'h70 + 8'(4*c), 32'hFFFF_FFFF);
            rd(8'h60 + 8'(4*c), d); check("R7 pend write ignored", d, r);
        end
        rd(8'h10, d); check("R7 pmu untouched", d, 32'h4);
        gpu_src = 1'b0; tmr_src = '0; mbx_src = '0; pmu_src = '0;
        #1;
        check("R7 no latching irq", {28'd0, irq_out}, 32'h0);
        check("R7 no latching fiq", {28'd0, fiq_out}, 32'h0);

        // random mix: config writes while sources move
        for (int it = 0; it < 400; it++) begin
            int kind = int'($urandom_range(0, 5));
            int c    = int'($urandom_range(0, NC-1));
            tmr_src = 16'($urandom);
            mbx_src = 16'($urandom);
            gpu_src = 1'($urandom);
            pmu_src = 4'($urandom);
            case (kind)
                0: wr(8'h40 + 8'(4*c), $urandom);
                1: wr(8'h50 + 8'(4*c), $urandom);
                2: wr(8'h0C, $urandom);
                3: wr(8'h10, $urandom);
                4: wr(8'h14, $urandom);
                default: @(negedge clk);
            endcase
            check_all("R2/R3/R4/R5 random");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule